// File: doc/BRIEF.md
# Filter Delay Measurement Capture Channel

This block is one timer channel that takes a single edge and compares against a single match value. It also measures how long its own input filter held back the edge it detected. The channel receives the raw input after synchronization. A stable-count filter inside the block samples that input on every second clock and produces a cleaned version. Two timebase values arrive from outside, and one select picks which of them feeds the captures and the match comparator.

Capture A stores the timebase either when a qualified edge appears on the filtered signal or when the timebase reaches the match value. Capture B follows the raw input and stores the timebase on every qualified raw edge. It stops updating once a filtered edge has been taken. At that point A minus B is the latency of the filter, or a shorter value if noise on the raw input produced late raw edges.

Software handles the service request and then pulses the clear input. The clear drops both flags and lets capture B follow the raw input again.

Top module: `fdc_channel`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `capA`, `capB`, `filtOut`, `transFlag`, `matchFlag` and `srvReq` are all zero.
- R2: Both edge-select fields use the same code: 00 qualifies no edge, 01 qualifies rising edges, 10 qualifies falling edges and 11 qualifies both. An edge that is not qualified leaves the captures and the flags unchanged.
- R3: `filtOut` can change only on a sample clock, and a sample clock comes every second cycle after reset. It takes the value of `rawIn` once `rawIn` has differed from it for `filtLen` consecutive samples. A `filtLen` of 0 counts as 1.
- R4: While `transFlag` is clear, a qualified raw edge loads the selected timebase into `capB` at the clock edge where `rawIn` first shows its new value.
- R5: While `transFlag` is clear, a qualified filtered edge loads the selected timebase into `capA` and sets both `transFlag` and `srvReq`. This happens one clock after `filtOut` changes.
- R6: While `transFlag` is set, `capB` holds its value. A raw edge at the same clock edge as the filtered detection is still stored.
- R7: While both flags are clear and `matchEn` is high, a selected timebase equal to `matchVal` loads `capA` and sets `matchFlag` and `srvReq`. If a qualified filtered edge comes in the same cycle, the filtered edge wins and `matchFlag` stays clear.
- R8: After a match, a later qualified filtered edge still loads `capA` and sets `transFlag`.
- R9: `clrFlags` clears `transFlag`, `matchFlag` and `srvReq`, which lets raw edges load `capB` again. An event accepted in the same cycle takes priority over the clear.
- R10: When `tbSel` is 0, `timeBase0` feeds both captures and the match comparator. When it is 1, `timeBase1` feeds them.
- R11: For a single clean edge with a filter length L and a timebase that advances by one per clock, `capA` minus `capB` is 2L-1 or 2L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawIn | input | 1 | Synchronized, unfiltered input |
| timeBase0 | input | TW | First timebase |
| timeBase1 | input | TW | Second timebase |
| tbSel | input | 1 | Timebase select |
| matchVal | input | TW | Match comparison value |
| matchEn | input | 1 | Match enable |
| edgeSelA | input | 2 | Edge code for filtered detection |
| edgeSelB | input | 2 | Edge code for raw capture |
| filtLen | input | FW | Filter sample count |
| clrFlags | input | 1 | Clear flags and rearm capture B |
| capA | output | TW | Capture A |
| capB | output | TW | Capture B |
| filtOut | output | 1 | Filtered input |
| transFlag | output | 1 | Filtered transition detected |
| matchFlag | output | 1 | Match recognised |
| srvReq | output | 1 | Service request |

## Verification
Several coincidences are hard to reach from the ports. A raw edge has to land in the same cycle as the filtered detection, a clear has to meet an accepted event, and a match has to meet a filtered edge. The latency from `rawIn` through the filter depends on the sample phase, so directed timing alone rarely lines these up. After the directed cases, the bench therefore runs a long pseudo-random phase. In that phase the raw input, the edge codes, the match window and the clear pulses all change together. A behavioural model is compared with the block on every clock, so these collisions are checked wherever they happen.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef struct packed {
    logic rawB;
    logic filtA;
    logic match;
  } fdcEvt_t;

  typedef struct packed {
    logic loadA;
    logic loadB;
  } fdcStrobe_t;

  function automatic logic edgeQual(input logic [1:0] code, input logic rise, input logic fall);
    return (code[0] & rise) | (code[1] & fall);
  endfunction

endpackage

// File: rtl/fdc_filter.sv
module fdc_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rawIn,
  input  logic [FW-1:0] filtLen,
  output logic          filtOut
);
  logic          tick;
  logic [FW-1:0] cnt;
  logic [FW:0]   lenEff;
  logic [FW:0]   cntNext;

  assign lenEff  = (filtLen == '0) ? (FW+1)'(1) : {1'b0, filtLen};
  assign cntNext = {1'b0, cnt} + (FW+1)'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick    <= 1'b0;
      cnt     <= '0;
      filtOut <= 1'b0;
    end else begin
      tick <= ~tick;
      if (tick) begin
        if (rawIn != filtOut) begin
          if (cntNext >= lenEff) begin
            filtOut <= rawIn;
            cnt     <= '0;
          end else begin
            cnt <= cntNext[FW-1:0];
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  assert_filt_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtOut) |-> $past(tick));

endmodule

// File: rtl/fdc_datapath.sv
module fdc_datapath
  import fdc_pkg::*;
#(
  parameter int TW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rawIn,
  input  logic [TW-1:0] timeBase0,
  input  logic [TW-1:0] timeBase1,
  input  logic          tbSel,
  input  logic [TW-1:0] matchVal,
  input  logic          matchEn,
  input  logic [1:0]    edgeSelA,
  input  logic [1:0]    edgeSelB,
  input  logic [FW-1:0] filtLen,
  input  fdcStrobe_t    str,
  output fdcEvt_t       ev,
  output logic [TW-1:0] capA,
  output logic [TW-1:0] capB,
  output logic          filtOut
);
  logic          rawPrev;
  logic          filtPrev;
  logic [TW-1:0] tbCur;

  fdc_filter #(.FW(FW)) uFilt (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (rawIn),
    .filtLen (filtLen),
    .filtOut (filtOut)
  );

  assign tbCur    = tbSel ? timeBase1 : timeBase0;
  assign ev.rawB  = edgeQual(edgeSelB, rawIn & ~rawPrev, ~rawIn & rawPrev);
  assign ev.filtA = edgeQual(edgeSelA, filtOut & ~filtPrev, ~filtOut & filtPrev);
  assign ev.match = matchEn && (tbCur == matchVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPrev  <= 1'b0;
      filtPrev <= 1'b0;
      capA     <= '0;
      capB     <= '0;
    end else begin
      rawPrev  <= rawIn;
      filtPrev <= filtOut;
      if (str.loadA) capA <= tbCur;
      if (str.loadB) capB <= tbCur;
    end
  end

  assert_capa_on_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capA) |-> $past(str.loadA));

endmodule

// File: rtl/fdc_control.sv
module fdc_control
  import fdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  fdcEvt_t    ev,
  input  logic       clrFlags,
  output fdcStrobe_t str,
  output logic       transFlag,
  output logic       matchFlag,
  output logic       srvReq
);
  logic takeT;
  logic takeM;

  assign takeT     = ev.filtA && !transFlag;
  assign takeM     = ev.match && !transFlag && !matchFlag && !takeT;
  assign str.loadA = takeT || takeM;
  assign str.loadB = ev.rawB && !transFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      transFlag <= 1'b0;
      matchFlag <= 1'b0;
      srvReq    <= 1'b0;
    end else begin
      if (clrFlags) begin
        transFlag <= 1'b0;
        matchFlag <= 1'b0;
        srvReq    <= 1'b0;
      end
      if (takeT) transFlag <= 1'b1;
      if (takeM) matchFlag <= 1'b1;
      if (takeT || takeM) srvReq <= 1'b1;
    end
  end

  assert_match_not_with_trans_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> !$rose(transFlag));

  assert_srv_has_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    srvReq |-> (transFlag || matchFlag));

endmodule

// File: rtl/fdc_channel.sv
module fdc_channel
  import fdc_pkg::*;
#(
  parameter int TW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rawIn,
  input  logic [TW-1:0] timeBase0,
  input  logic [TW-1:0] timeBase1,
  input  logic          tbSel,
  input  logic [TW-1:0] matchVal,
  input  logic          matchEn,
  input  logic [1:0]    edgeSelA,
  input  logic [1:0]    edgeSelB,
  input  logic [FW-1:0] filtLen,
  input  logic          clrFlags,
  output logic [TW-1:0] capA,
  output logic [TW-1:0] capB,
  output logic          filtOut,
  output logic          transFlag,
  output logic          matchFlag,
  output logic          srvReq
);
  fdcEvt_t    ev;
  fdcStrobe_t str;

  fdc_datapath #(.TW(TW), .FW(FW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     (rawIn),
    .timeBase0 (timeBase0),
    .timeBase1 (timeBase1),
    .tbSel     (tbSel),
    .matchVal  (matchVal),
    .matchEn   (matchEn),
    .edgeSelA  (edgeSelA),
    .edgeSelB  (edgeSelB),
    .filtLen   (filtLen),
    .str       (str),
    .ev        (ev),
    .capA      (capA),
    .capB      (capB),
    .filtOut   (filtOut)
  );

  fdc_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .ev        (ev),
    .clrFlags  (clrFlags),
    .str       (str),
    .transFlag (transFlag),
    .matchFlag (matchFlag),
    .srvReq    (srvReq)
  );

  assert_capb_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (transFlag && !clrFlags) |=> $stable(capB));

endmodule

// File: tb/sim_fdc_channel.sv
module sim_fdc_channel;
  localparam int TW = 16;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rawIn = 1'b0;
  logic [TW-1:0] timeBase0 = '0;
  logic [TW-1:0] timeBase1 = 16'h8000;
  logic          tbSel = 1'b0;
  logic [TW-1:0] matchVal = '0;
  logic          matchEn = 1'b0;
  logic [1:0]    edgeSelA = 2'b01;
  logic [1:0]    edgeSelB = 2'b01;
  logic [FW-1:0] filtLen = 4'd3;
  logic          clrFlags = 1'b0;
  logic [TW-1:0] capA, capB;
  logic          filtOut, transFlag, matchFlag, srvReq;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  fdc_channel #(.TW(TW), .FW(FW)) u0 (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .timeBase0(timeBase0), .timeBase1(timeBase1),
    .tbSel(tbSel), .matchVal(matchVal), .matchEn(matchEn), .edgeSelA(edgeSelA),
    .edgeSelB(edgeSelB), .filtLen(filtLen), .clrFlags(clrFlags), .capA(capA), .capB(capB),
    .filtOut(filtOut), .transFlag(transFlag), .matchFlag(matchFlag), .srvReq(srvReq)
  );

  always #2 clk = ~clk;

  // Timebases: base0 counts up by one per clock, base1 stays in the upper half.
  always @(posedge clk) begin
    #1;
    timeBase0 <= (timeBase0 + 16'd1) & 16'h7fff;
    timeBase1 <= timeBase1 + 16'd3 | 16'h8000;
  end

  // Behavioural reference model.
  int mCapA, mCapB, mFilt, mRawPrev, mFiltPrev, mCnt, mTick, mTrans, mMatch, mSrv;

  function automatic bit qual(input logic [1:0] code, input int prev, input int cur);
    if (prev == 0 && cur == 1) return code == 2'b01 || code == 2'b11;
    if (prev == 1 && cur == 0) return code == 2'b10 || code == 2'b11;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCapA = 0; mCapB = 0; mFilt = 0; mRawPrev = 0; mFiltPrev = 0;
      mCnt = 0; mTick = 0; mTrans = 0; mMatch = 0; mSrv = 0;
    end else begin
      int tb, raw, len, nFilt, nCnt;
      bit evB, evA, evM, tT, tM;
      tb  = tbSel ? int'(timeBase1) : int'(timeBase0);
      raw = int'(rawIn);
      len = (filtLen == 0) ? 1 : int'(filtLen);
      evB = qual(edgeSelB, mRawPrev, raw);
      evA = qual(edgeSelA, mFiltPrev, mFilt);
      evM = matchEn && (tb == int'(matchVal));
      tT  = evA && mTrans == 0;
      tM  = evM && mTrans == 0 && mMatch == 0 && !tT;
      if (evB && mTrans == 0) mCapB = tb;
      if (tT || tM) mCapA = tb;
      if (clrFlags) begin mTrans = 0; mMatch = 0; mSrv = 0; end
      if (tT) mTrans = 1;
      if (tM) mMatch = 1;
      if (tT || tM) mSrv = 1;
      nFilt = mFilt; nCnt = mCnt;
      if (mTick == 1) begin
        if (raw != mFilt) begin
          nCnt = mCnt + 1;
          if (nCnt >= len) begin nFilt = raw; nCnt = 0; end
        end else nCnt = 0;
      end
      mFiltPrev = mFilt;
      mFilt = nFilt; mCnt = nCnt;
      mTick = 1 - mTick;
      mRawPrev = raw;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rstN) begin
      check(int'(capB) == mCapB, "R4", "capB", int'(capB), mCapB);
      check(int'(capA) == mCapA, "R5", "capA", int'(capA), mCapA);
      check(int'(filtOut) == mFilt, "R3", "filtOut", int'(filtOut), mFilt);
      check(int'(transFlag) == mTrans, "R5", "transFlag", int'(transFlag), mTrans);
      check(int'(matchFlag) == mMatch, "R7", "matchFlag", int'(matchFlag), mMatch);
      check(int'(srvReq) == mSrv, "R9", "srvReq", int'(srvReq), mSrv);
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulseClr();
    clrFlags = 1'b1;
    waitCyc(1);
    clrFlags = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      finishRun();
    end
  end

  initial begin
    int hold;
    logic [15:0] lfsr;
    waitCyc(4);
    // R1: reset state
    check(capA == 0 && capB == 0 && !filtOut && !transFlag && !matchFlag && !srvReq,
          "R1", "reset outputs", int'(capA) + int'(capB), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(capA == 0 && capB == 0 && !transFlag && !srvReq, "R1", "first cycle", int'(capA), 0);
    waitCyc(3);

    // R11: clean rising edge, L=3, base0 one per clock
    rawIn = 1'b1;
    waitCyc(14);
    check(transFlag == 1'b1, "R5", "filtered rise detected", int'(transFlag), 1);
    check(int'(capA - capB) >= 5 && int'(capA - capB) <= 6, "R11", "delay A-B",
          int'(capA - capB), 6);
    pulseClr();
    check(transFlag == 1'b0 && srvReq == 1'b0, "R9", "clear", int'(srvReq), 0);

    // R6: noisy fall with both edges on B, then toggling while frozen
    edgeSelA = 2'b10; edgeSelB = 2'b11;
    rawIn = 1'b0; waitCyc(1); rawIn = 1'b1; waitCyc(1); rawIn = 1'b0;
    waitCyc(14);
    check(transFlag == 1'b1, "R6", "filtered fall detected", int'(transFlag), 1);
    hold = int'(capB);
    for (int i = 0; i < 6; i++) begin rawIn = ~rawIn; waitCyc(1); end
    check(int'(capB) == hold, "R6", "capB frozen", int'(capB), hold);
    rawIn = 1'b0; waitCyc(14);
    pulseClr();

    // R2: unqualified edges do nothing (B on falling only, A on falling only)
    edgeSelB = 2'b10;
    hold = int'(capB);
    rawIn = 1'b1; waitCyc(14);
    check(int'(capB) == hold, "R2", "rise ignored by B", int'(capB), hold);
    check(transFlag == 1'b0, "R2", "rise ignored by A", int'(transFlag), 0);

    // R7 then R8: match first, then filtered fall
    edgeSelB = 2'b01;
    matchVal = (timeBase0 + 16'd6) & 16'h7fff;
    matchEn = 1'b1;
    waitCyc(10);
    check(matchFlag == 1'b1 && transFlag == 1'b0, "R7", "match flag", int'(matchFlag), 1);
    check(capA == matchVal, "R7", "capA on match", int'(capA), int'(matchVal));
    matchEn = 1'b0;
    rawIn = 1'b0; waitCyc(14);
    check(transFlag == 1'b1, "R8", "edge after match", int'(transFlag), 1);
    pulseClr();

    // R10: second timebase
    tbSel = 1'b1; edgeSelA = 2'b11; edgeSelB = 2'b11;
    rawIn = 1'b1; waitCyc(14);
    check(capB[15] == 1'b1 && capA[15] == 1'b1, "R10", "base1 selected", int'(capB[15]), 1);
    pulseClr();

    // R3: zero length treated as one
    tbSel = 1'b0; filtLen = 4'd0;
    rawIn = 1'b0; waitCyc(4);
    check(filtOut == 1'b0, "R3", "len 0 follows raw", int'(filtOut), 0);
    pulseClr();

    // Randomised collisions: edges, matches, clears, codes
    lfsr = 16'hace1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] < 3'd3) rawIn = ~rawIn;
      clrFlags = (lfsr[7:4] == 4'd0);
      if (lfsr[11:8] == 4'd5) begin edgeSelA = lfsr[13:12]; edgeSelB = lfsr[15:14]; end
      if (lfsr[11:8] == 4'd9) filtLen = lfsr[15:12] & 4'h3;
      if (lfsr[11:8] == 4'd3) tbSel = lfsr[12];
      matchEn = lfsr[9];
      if (lfsr[11:8] == 4'd7) matchVal = tbSel ? timeBase1 + 16'd6 | 16'h8000
                                               : (timeBase0 + 16'd4) & 16'h7fff;
      waitCyc(1);
    end
    clrFlags = 1'b0;
    waitCyc(4);
    finishRun();
  end
endmodule